// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the device end of a serial-peripheral-interface flash that answers two read commands. It watches the chip select, serial clock and serial data-in pins with its own system clock. It decodes an 8-bit command, collects a 24-bit byte address, and for the fast variant it also skips eight dummy clocks. It then streams bytes from an on-chip byte array out on the serial data-out pin for as long as chip select stays low. After each byte the address moves up by one, and at the top of the array it wraps to zero.

A `busy` input stands for an erase, program or write cycle that is in progress elsewhere. A read command whose last opcode bit arrives while `busy` is high is not served. The array is filled through a simple synchronous backdoor write port, which tests use to preload it.

Top module: `sflash_read_resp`

## Requirements
- R1: After reset, while chip select is high, and at any time outside an accepted data phase, `spi_miso_oe` is 0 and `spi_miso` is 0.
- R2: Opcode and address bits are taken MSB first on rising SCK edges. Opcode 0x03 is followed at once by 24 address bits, and data starts right after them.
- R3: Opcode 0x0B is followed by 24 address bits and then 8 dummy clocks, whose data-in values are ignored. Data starts after the dummy clocks.
- R4: Data bits are driven MSB first and change on falling SCK edges. The first bit appears on the fall that ends the last address or dummy clock. The first byte is the one at the received address modulo the array depth, so address bits at or above ADDR_W are ignored.
- R5: After every 8 data bits the byte address advances by one, and streaming continues for as long as chip select is low.
- R6: After the byte at address 2^ADDR_W-1, the stream continues with the byte at address 0.
- R7: Raising chip select ends the command at any point, including in the middle of a byte. The next falling edge of chip select starts a fresh opcode decode.
- R8: If `busy` is 1 on the SCK rise that takes the 8th opcode bit, the transaction produces no output until chip select rises.
- R9: Any opcode other than 0x03 and 0x0B makes the block ignore the rest of the transaction until chip select rises.
- R10: The pins pass through two clk register stages. `spi_miso_oe` and `spi_miso` change on the second clk rising edge after an SCK fall or a chip-select rise at the pins.
- R11: When `bd_we` is 1 at a rising clk edge, `bd_wdata` is written to the byte at `bd_addr`, and later reads of that address return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data in |
| busy | input | 1 | High while an erase, program or write cycle is running |
| bd_we | input | 1 | Backdoor write enable |
| bd_addr | input | ADDR_W | Backdoor write address |
| bd_wdata | input | 8 | Backdoor write data |
| spi_miso | output | 1 | Serial data out; 0 when not enabled |
| spi_miso_oe | output | 1 | Output enable for serial data out |

## Verification
The assertions take for granted that the serial pins are slow next to `clk`: each SCK half period lasts at least three clk cycles, SCK is low whenever chip select changes, and `busy` is steady around the opcode's last rising edge. The bench meets these assumptions in the following ways:
- It drives every pin on falling clk edges with a four-cycle SCK half period.
- It holds SCK low across every chip-select edge.
- It changes `busy` only while chip select is high.

// File: rtl/sfr_pkg.sv
// Shared types for the serial flash read responder.
// Assumes: the opcode values below are the only commands that get served.
package sfr_pkg;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_SKIP
    } sfr_state_e;

    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_FAST = 8'h0B;
    localparam int unsigned ADDR_BITS_ON_WIRE = 24;
    localparam int unsigned CMD_BITS = 8;
    localparam int unsigned DUMMY_BITS = 8;

endpackage

// File: rtl/sfr_pin_sync.sv
// Registers the serial pins into the clk domain and finds the SCK edges.
// Assumes: each SCK half period lasts at least three clk cycles, so that
// one register stage is enough to sample DI and chip select cleanly.
module sfr_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic di_pin,
    output logic cs_hi,
    output logic di,
    output logic sck_rise,
    output logic sck_fall
);

    logic sck_s1, sck_s2, cs_s1, di_s1;

    // Sampling stages for the three serial inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s1 <= 1'b0;
            sck_s2 <= 1'b0;
            cs_s1  <= 1'b1;
            di_s1  <= 1'b0;
        end else begin
            sck_s1 <= sck_pin;
            sck_s2 <= sck_s1;
            cs_s1  <= cs_n_pin;
            di_s1  <= di_pin;
        end
    end

    // Edge strobes and sampled levels for the command logic.
    always_comb begin
        sck_rise = sck_s1 & ~sck_s2;
        sck_fall = ~sck_s1 & sck_s2;
        cs_hi    = cs_s1;
        di       = di_s1;
    end

endmodule

// File: rtl/sfr_byte_store.sv
// Byte array of depth 2^ADDR_W. It has one synchronous backdoor write port
// and one combinational read port.
// Assumes: read and write never need to be ordered within one cycle.
module sfr_byte_store #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    // Backdoor load of one byte.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Read port used by the output shifter.
    always_comb begin
        rd_data = mem_q[rd_addr];
    end

endmodule

// File: rtl/sfr_cmd_fsm.sv
// Command sequencer. It runs the opcode, address and dummy phases on SCK
// rises, then shifts data out on SCK falls with a wrapping byte address.
// Assumes: cs_hi, di and the SCK strobes come from sfr_pin_sync,
// 2 <= ADDR_W <= 24, and busy is steady around the last opcode bit.
module sfr_cmd_fsm
    import sfr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi,
    input  logic              di,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              busy,
    input  logic [7:0]        rd_byte,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              so_bit,
    output logic              so_en
);

    localparam logic [4:0] CMD_LAST   = 5'(CMD_BITS - 1);
    localparam logic [4:0] ADDR_LAST  = 5'(ADDR_BITS_ON_WIRE - 1);
    localparam logic [4:0] DUMMY_LAST = 5'(DUMMY_BITS - 1);

    sfr_state_e        state;
    logic [4:0]        cnt;
    logic [6:0]        op_sh;
    logic [7:0]        op_next;
    logic              fast_q;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        bit_idx;
    logic              started;
    logic              out_bit;

    // Opcode as it will stand once the current DI bit is shifted in.
    always_comb begin
        op_next = {op_sh, di};
    end

    // Phase sequencing, address capture and output shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CMD;
            cnt     <= '0;
            op_sh   <= '0;
            fast_q  <= 1'b0;
            addr_q  <= '0;
            bit_idx <= '0;
            started <= 1'b0;
            out_bit <= 1'b0;
        end else if (cs_hi) begin
            state   <= ST_CMD;
            cnt     <= '0;
            started <= 1'b0;
            out_bit <= 1'b0;
        end else begin
            unique case (state)
                ST_CMD: if (sck_rise) begin
                    op_sh <= op_next[6:0];
                    if (cnt == CMD_LAST) begin
                        cnt <= '0;
                        if (!busy && op_next == OP_READ) begin
                            state  <= ST_ADDR;
                            fast_q <= 1'b0;
                        end else if (!busy && op_next == OP_FAST) begin
                            state  <= ST_ADDR;
                            fast_q <= 1'b1;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end else begin
                        cnt <= cnt + 5'd1;
                    end
                end
                ST_ADDR: if (sck_rise) begin
                    addr_q <= {addr_q[ADDR_W-2:0], di};
                    if (cnt == ADDR_LAST) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= fast_q ? ST_DUMMY : ST_DATA;
                    end else begin
                        cnt <= cnt + 5'd1;
                    end
                end
                ST_DUMMY: if (sck_rise) begin
                    if (cnt == DUMMY_LAST) begin
                        cnt   <= '0;
                        state <= ST_DATA;
                    end else begin
                        cnt <= cnt + 5'd1;
                    end
                end
                ST_DATA: if (sck_fall) begin
                    started <= 1'b1;
                    out_bit <= rd_byte[3'd7 - bit_idx];
                    bit_idx <= bit_idx + 3'd1;
                    if (bit_idx == 3'd7) begin
                        addr_q <= addr_q + ADDR_W'(1);
                    end
                end
                ST_SKIP: ;
                default: state <= ST_SKIP;
            endcase
        end
    end

    // Outputs toward the byte store and the pin.
    always_comb begin
        rd_addr = addr_q;
        so_bit  = out_bit;
        so_en   = (state == ST_DATA) && started;
    end

    // R8
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && $past(state) == ST_CMD) |-> !$past(busy));

    // R3
    dummy_only_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DUMMY) |-> fast_q);

    // R7
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_hi) |=> !so_en);

    // R4
    shift_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) == ST_DATA && !$stable(bit_idx))
        |-> $past(sck_fall));

    // R9
    skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP && !cs_hi) |=> (state == ST_SKIP));

endmodule

// File: rtl/sflash_read_resp.sv
// Top of the serial flash read responder. It ties together pin sampling,
// the command sequencer and the byte store.
// Assumes: SCK is idle low, each SCK half period is at least three clk
// cycles, and busy comes from the local write/erase controller.
module sflash_read_resp #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              busy,
    input  logic              bd_we,
    input  logic [ADDR_W-1:0] bd_addr,
    input  logic [7:0]        bd_wdata,
    output logic              spi_miso,
    output logic              spi_miso_oe
);

    logic              cs_hi, di, sck_rise, sck_fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_byte;
    logic              so_bit, so_en;

    sfr_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_pin (spi_cs_n),
        .sck_pin  (spi_sck),
        .di_pin   (spi_mosi),
        .cs_hi    (cs_hi),
        .di       (di),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    sfr_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_hi    (cs_hi),
        .di       (di),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .busy     (busy),
        .rd_byte  (rd_byte),
        .rd_addr  (rd_addr),
        .so_bit   (so_bit),
        .so_en    (so_en)
    );

    sfr_byte_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (bd_we),
        .wr_addr (bd_addr),
        .wr_data (bd_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_byte)
    );

    // Data-out pin held at 0 whenever it is not enabled.
    always_comb begin
        spi_miso_oe = so_en;
        spi_miso    = so_en & so_bit;
    end

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso_oe);

endmodule

// File: tb/sflash_read_resp_tb_top.sv
`timescale 1ns/1ps
module sflash_read_resp_tb_top;

    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF   = 4;
    localparam int WD_LIM = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, busy = 1'b0;
    logic bd_we = 1'b0;
    logic [ADDR_W-1:0] bd_addr = '0;
    logic [7:0] bd_wdata = '0;
    logic spi_miso, spi_miso_oe;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";
    logic model_oe = 1'b0, oe_d1 = 1'b0, oe_d2 = 1'b0;

    always #2.5 clk = ~clk;

    sflash_read_resp #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .busy(busy), .bd_we(bd_we), .bd_addr(bd_addr),
        .bd_wdata(bd_wdata), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
    );

    function automatic logic [7:0] byte_at(int a);
        return 8'(a * 29 + 11);
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference: enable follows the bench's data window two clk edges late (R10).
    always @(posedge clk) begin
        oe_d1 <= rst_n ? model_oe : 1'b0;
        oe_d2 <= rst_n ? oe_d1 : 1'b0;
    end

    // Per-clock comparison against the reference (R1, R10).
    always @(negedge clk) begin
        if (rst_n) begin
            chk(spi_miso_oe === oe_d2, "oe", int'(spi_miso_oe), int'(oe_d2));
            if (spi_miso_oe !== 1'b1)
                chk(spi_miso === 1'b0, "idle miso", int'(spi_miso), 0);
        end
    end

    task automatic send_bit(input logic b, input bit last_hdr, input bit accept);
        spi_mosi = b;
        tick(HALF);
        spi_sck = 1'b1;
        tick(HALF);
        spi_sck = 1'b0;
        if (last_hdr && accept) model_oe = 1'b1;
    endtask

    // One transaction: opcode, address, dummy bytes, then nbits data clocks.
    task automatic xfer(input logic [7:0] op, input logic [23:0] addr,
                        input int dummies, input bit accept, input int nbits);
        int hdr_total;
        int hdr_n;
        int base;
        hdr_total = 32 + 8 * dummies;
        hdr_n = 0;
        base = int'(addr[ADDR_W-1:0]);
        spi_cs_n = 1'b0;
        tick(HALF);
        for (int i = 7; i >= 0; i--) begin
            hdr_n++;
            send_bit(op[i], hdr_n == hdr_total, accept);
        end
        for (int i = 23; i >= 0; i--) begin
            hdr_n++;
            send_bit(addr[i], hdr_n == hdr_total, accept);
        end
        for (int i = 0; i < 8 * dummies; i++) begin
            hdr_n++;
            send_bit(1'b1, hdr_n == hdr_total, accept);
        end
        for (int k = 0; k < nbits; k++) begin
            logic [7:0] eb;
            logic ebit;
            eb = byte_at((base + k / 8) % DEPTH);
            ebit = accept ? eb[7 - (k % 8)] : 1'b0;
            spi_mosi = 1'b0;
            tick(HALF);
            chk(spi_miso === ebit, $sformatf("data bit %0d", k), int'(spi_miso), int'(ebit));
            spi_sck = 1'b1;
            tick(HALF);
            spi_sck = 1'b0;
        end
        tick(HALF);
        spi_cs_n = 1'b1;
        model_oe = 1'b0;
        tick(3 * HALF);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (WD_LIM) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog %s act=timeout exp=done", cur_req);
        summary();
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        cur_req = "R1";
        chk(spi_miso_oe === 1'b0, "reset oe", int'(spi_miso_oe), 0);
        chk(spi_miso === 1'b0, "reset miso", int'(spi_miso), 0);

        // R11: preload through the backdoor port
        for (int i = 0; i < DEPTH; i++) begin
            bd_we = 1'b1;
            bd_addr = ADDR_W'(i);
            bd_wdata = byte_at(i);
            tick(1);
        end
        bd_we = 1'b0;
        tick(4);

        cur_req = "R2 R4 R5 R10 R11";
        xfer(8'h03, 24'h000010, 0, 1'b1, 32);

        cur_req = "R3";
        xfer(8'h0B, 24'h000021, 1, 1'b1, 24);

        cur_req = "R6";
        xfer(8'h03, 24'h0000FE, 0, 1'b1, 32);

        cur_req = "R4 R6";
        xfer(8'h0B, 24'h7F3AFF, 1, 1'b1, 16);

        cur_req = "R7";
        xfer(8'h03, 24'h000040, 0, 1'b1, 12);
        xfer(8'h03, 24'h000041, 0, 1'b1, 8);

        cur_req = "R8";
        busy = 1'b1;
        tick(2);
        xfer(8'h03, 24'h000050, 0, 1'b0, 16);
        xfer(8'h0B, 24'h000060, 1, 1'b0, 16);
        busy = 1'b0;
        tick(2);
        xfer(8'h03, 24'h000050, 0, 1'b1, 8);

        cur_req = "R9";
        xfer(8'h05, 24'h000003, 0, 1'b0, 16);
        xfer(8'h9F, 24'h000000, 0, 1'b0, 16);
        cur_req = "R9 R7";
        xfer(8'h03, 24'h000077, 0, 1'b1, 8);

        summary();
        $finish;
    end

endmodule